// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive side of a serial port that owns the shift clock. It divides the system clock into a serial clock and drives it out to a slave. It takes one data bit from the slave on every falling edge of that clock. A word is 8 bits, or 9 bits when the wide mode is selected, and it arrives least significant bit first. Each finished word moves from the shift register into a two-entry receive FIFO. The FIFO stores the ninth bit together with its byte.

Software has two ways to start reception. A one-shot request fetches exactly one word and then clears itself. A continuous enable keeps the clock running for as long as it stays high, and it wins when both are active. The FIFO head is always visible at the outputs, and a read strobe pops it. When a word finishes and the FIFO has no room, the word is dropped and a sticky overrun flag is raised. That flag blocks every later load until the continuous enable is dropped.

Top module: `sync_mrx`

## Requirements
- R1: The serial clock has a period of 4 × (div_i + 1) system clocks. It is high for the first half of each period and low for the second. It stays low whenever neither reception request is active.
- R2: A data bit is taken on each falling edge of sclk_o, least significant bit first. A word has 8 bits when nine_bit_i is 0 and 9 bits when it is 1. The ninth bit received appears on rx_bit9_o. In 8-bit mode rx_bit9_o is 0.
- R3: A pulse on single_set_i receives exactly one word. single_pend_o clears itself when that word completes, and sclk_o then stays low.
- R4: While cont_en_i is high, words are received back to back. Dropping cont_en_i stops the clock.
- R5: While cont_en_i is high, the one-shot request is cleared, and a pulse on single_set_i has no effect. Once cont_en_i falls, no reception is left pending.
- R6: The FIFO holds two words and shows its oldest entry on rx_data_o. A pulse on rd_i pops that entry. avail_o is high while the FIFO is not empty and clears once reads have emptied it. A pulse on rd_i with an empty FIFO is ignored.
- R7: Each FIFO entry carries its own ninth bit. rx_bit9_o changes to the next entry's value at the same time as rx_data_o.
- R8: When a word completes and the FIFO is full, ovr_o is set and the word is discarded. A read in that same cycle frees a slot, so the word is stored and no overrun occurs.
- R9: While ovr_o is set, no finished word enters the FIFO. Reads do not clear ovr_o. It clears only when cont_en_i falls.
- R10: After reset, sclk_o, avail_o, ovr_o and single_pend_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Baud divider value |
| nine_bit_i | input | 1 | 1 selects 9-bit words |
| single_set_i | input | 1 | Pulse that requests one word |
| cont_en_i | input | 1 | Continuous reception enable |
| rd_i | input | 1 | Pops the FIFO head |
| sdat_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Generated serial clock |
| rx_data_o | output | 8 | FIFO head data byte |
| rx_bit9_o | output | 1 | FIFO head ninth bit |
| avail_o | output | 1 | FIFO not empty |
| ovr_o | output | 1 | Sticky overrun flag |
| single_pend_o | output | 1 | One-shot request still active |

## Verification
A read can pop the FIFO in the same cycle that a third word completes while both entries are full. This collision decides whether the word overruns or is stored. The bench fills the FIFO in continuous mode and counts serial clock rises until the last bit of the third word. It then counts system clocks from that rise and places the read strobe in the cycle just before the falling edge. The test passes when ovr_o stays clear, the second and third words then come out in order with their ninth bits, and the FIFO ends empty. A second collision is between the continuous enable and a one-shot pulse. Both are raised together, and the check is that the one-shot request never registers.

// File: rtl/sync_mrx_pkg.sv
package sync_mrx_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              b9;
    logic [BYTE_W-1:0] data;
  } rx_word_t;

  localparam int WORD_W = $bits(rx_word_t);
endpackage

// File: rtl/sync_mrx_clkgen.sv
module sync_mrx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [1:0]       ph_q;
  logic             tick;

  assign tick   = (cnt_q == div_i);
  assign sclk_o = run_i & ~ph_q[1];
  assign fall_o = run_i & tick & (ph_q == 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (tick) begin
      cnt_q <= '0;
      ph_q  <= ph_q + 2'd1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // sclk must be low right after each sample strobe
  a_r1_low_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !sclk_o);
endmodule

// File: rtl/sync_mrx_shift.sv
module sync_mrx_shift
  import sync_mrx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     sample_i,
  input  logic     sdat_i,
  input  logic     nine_i,
  output logic     done_o,
  output rx_word_t word_o
);
  localparam int SR_W = BYTE_W + 1;
  localparam int BCW  = $clog2(SR_W);

  logic [SR_W-1:0] sr_q, sr_nxt;
  logic [BCW-1:0]  bcnt_q;
  logic            last;

  assign last   = (bcnt_q == (nine_i ? BCW'(BYTE_W) : BCW'(BYTE_W - 1)));
  assign sr_nxt = {sdat_i, sr_q[SR_W-1:1]};
  assign done_o = sample_i & last;

  always_comb begin
    word_o.data = nine_i ? sr_nxt[BYTE_W-1:0] : sr_nxt[SR_W-1:1];
    word_o.b9   = nine_i & sr_nxt[SR_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      bcnt_q <= '0;
    end else if (!run_i) begin
      bcnt_q <= '0;
    end else if (sample_i) begin
      sr_q   <= sr_nxt;
      bcnt_q <= last ? '0 : bcnt_q + 1'b1;
    end
  end

  a_r2_bcnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcnt_q <= BCW'(BYTE_W));
endmodule

// File: rtl/sync_mrx_fifo.sv
module sync_mrx_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         room_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop     = pop_i & (cnt_q != '0);
  assign empty_o = (cnt_q == '0);
  // a same-cycle pop frees a slot for the incoming word
  assign room_o  = (cnt_q != CW'(DEPTH)) | pop;
  assign dout_o  = mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) begin
        mem_q[wptr_q] <= din_i;
        wptr_q        <= wrap_inc(wptr_q);
      end
      if (pop) rptr_q <= wrap_inc(rptr_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop);
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(DEPTH) && !pop_i) |-> !push_i);
  a_r6_avail_after_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> !empty_o);
endmodule

// File: rtl/sync_mrx.sv
module sync_mrx
  import sync_mrx_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             nine_bit_i,
  input  logic             single_set_i,
  input  logic             cont_en_i,
  input  logic             rd_i,
  input  logic             sdat_i,
  output logic             sclk_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_bit9_o,
  output logic             avail_o,
  output logic             ovr_o,
  output logic             single_pend_o
);
  logic     single_q, ovr_q, cont_d_q;
  logic     run, fall, done, room, empty, push;
  rx_word_t sh_word, head;

  assign run  = cont_en_i | single_q;
  assign push = done & room & ~ovr_q;

  sync_mrx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_i),
    .sclk_o (sclk_o),
    .fall_o (fall)
  );

  sync_mrx_shift u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .sample_i (fall),
    .sdat_i   (sdat_i),
    .nine_i   (nine_bit_i),
    .done_o   (done),
    .word_o   (sh_word)
  );

  sync_mrx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   (sh_word),
    .pop_i   (rd_i),
    .dout_o  (head),
    .empty_o (empty),
    .room_o  (room)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      single_q <= 1'b0;
      ovr_q    <= 1'b0;
      cont_d_q <= 1'b0;
    end else begin
      cont_d_q <= cont_en_i;
      if (cont_en_i)         single_q <= 1'b0;
      else if (single_set_i) single_q <= 1'b1;
      else if (done)         single_q <= 1'b0;
      // falling continuous enable clears overrun, with priority
      if (cont_d_q && !cont_en_i) ovr_q <= 1'b0;
      else if (done && !room)     ovr_q <= 1'b1;
    end
  end

  assign rx_data_o     = head.data;
  assign rx_bit9_o     = head.b9;
  assign avail_o       = ~empty;
  assign ovr_o         = ovr_q;
  assign single_pend_o = single_q;

  a_r3_single_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !cont_en_i && !single_set_i) |=> !single_pend_o);
  a_r5_cont_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_en_i |=> !single_pend_o);
  a_r9_ovr_blocks_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !avail_o) |=> !avail_o);
  a_r9_ovr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cont_en_i) |=> !ovr_o);
  a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cont_en_i && !single_pend_o) |-> !sclk_o);
endmodule

// File: tb/sync_mrx_tb_top.sv
module sync_mrx_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] div_i = '0;
  logic       nine_bit_i = 1'b0;
  logic       single_set_i = 1'b0;
  logic       cont_en_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       sdat_i = 1'b0;
  logic       sclk_o, rx_bit9_o, avail_o, ovr_o, single_pend_o;
  logic [7:0] rx_data_o;

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  always #5 clk_i = ~clk_i;

  sync_mrx dut_i (.*);

  // slave model: drives the next bit on each rising sclk
  logic [8:0] tx_q [16];
  int tx_ptr = 0, bitpos = 0, rise_cnt = 0, nb = 8;
  always @(posedge sclk_o) begin
    sdat_i <= tx_q[tx_ptr % 16][bitpos];
    rise_cnt = rise_cnt + 1;
    if (bitpos == nb - 1) begin
      bitpos = 0;
      tx_ptr = tx_ptr + 1;
    end else bitpos = bitpos + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic slave_reset(input int bits);
    tx_ptr = 0; bitpos = 0; rise_cnt = 0; nb = bits;
  endtask

  task automatic pop();
    rd_i = 1'b1;
    @(posedge clk_i); #1 rd_i = 1'b0;
  endtask

  task automatic wait_avail(input int limit);
    for (int i = 0; i < limit && !avail_o; i++) @(negedge clk_i);
  endtask

  // {div, nine, word}
  localparam logic [17:0] VEC [6] = '{
    {8'd0, 1'b0, 9'h0A5},
    {8'd1, 1'b1, 9'h13C},
    {8'd3, 1'b0, 9'h1FF},
    {8'd2, 1'b1, 9'h000},
    {8'd5, 1'b1, 9'h155},
    {8'd0, 1'b1, 9'h1C3}
  };

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    time t2, t3, tf;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 sclk", sclk_o, 0);
    check("R10 avail", avail_o, 0);
    check("R10 ovr", ovr_o, 0);
    check("R10 pend", single_pend_o, 0);

    // R6: read on empty FIFO is ignored
    @(posedge clk_i); #1 pop();
    @(negedge clk_i);
    check("R6 empty read", avail_o, 0);

    // table-driven one-shot receptions (R2, R3, R6, R7)
    foreach (VEC[k]) begin
      logic [8:0] w;
      logic nine;
      @(posedge clk_i); #1;
      div_i = VEC[k][17:10];
      nine = VEC[k][9];
      w = VEC[k][8:0];
      nine_bit_i = nine;
      slave_reset(nine ? 9 : 8);
      tx_q[0] = w;
      single_set_i = 1'b1;
      @(posedge clk_i); #1 single_set_i = 1'b0;
      wait_avail(12000);
      check("R2 data", rx_data_o, w[7:0]);
      check("R7 bit9", rx_bit9_o, nine & w[8]);
      check("R3 pend clear", single_pend_o, 0);
      repeat (3) @(negedge clk_i);
      check("R3 clock idle", sclk_o, 0);
      check("R3 one word", rise_cnt, nine ? 9 : 8);
      @(posedge clk_i); #1 pop();
      @(negedge clk_i);
      check("R6 avail clear", avail_o, 0);
    end

    // continuous mode, fill then overrun (R1, R4, R8, R9)
    @(posedge clk_i); #1;
    div_i = 8'd1; nine_bit_i = 1'b0; slave_reset(8);
    tx_q[0] = 9'h011; tx_q[1] = 9'h022; tx_q[2] = 9'h033; tx_q[3] = 9'h044;
    cont_en_i = 1'b1;
    wait (rise_cnt == 2); t2 = $time;
    @(negedge sclk_o); tf = $time;
    wait (rise_cnt == 3); t3 = $time;
    check("R1 period", int'((t3 - t2) / 10), 8);
    check("R1 high", int'((tf - t2) / 10), 4);
    wait (rise_cnt == 25);
    @(negedge clk_i);
    check("R8 ovr set", ovr_o, 1);
    check("R8 head kept", rx_data_o, 8'h11);
    @(posedge clk_i); #1 pop();
    @(negedge clk_i);
    check("R6 second", rx_data_o, 8'h22);
    @(posedge clk_i); #1 pop();
    @(negedge clk_i);
    check("R6 drained", avail_o, 0);
    check("R9 ovr sticky", ovr_o, 1);
    wait (rise_cnt == 33);
    @(negedge clk_i);
    check("R9 load blocked", avail_o, 0);
    @(posedge clk_i); #1 cont_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R9 ovr cleared", ovr_o, 0);
    check("R4 clock stops", sclk_o, 0);

    // precedence (R5)
    @(posedge clk_i); #1;
    slave_reset(8);
    tx_q[0] = 9'h05A; tx_q[1] = 9'h0C3;
    cont_en_i = 1'b1; single_set_i = 1'b1;
    @(posedge clk_i); #1 single_set_i = 1'b0;
    @(negedge clk_i);
    check("R5 single ignored", single_pend_o, 0);
    wait (rise_cnt == 17);
    @(negedge clk_i);
    check("R4 word1", rx_data_o, 8'h5A);
    @(posedge clk_i); #1 pop();
    @(negedge clk_i);
    check("R4 word2", rx_data_o, 8'hC3);
    @(posedge clk_i); #1 pop(); cont_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R5 nothing pending", single_pend_o, 0);
    check("R5 clock stops", sclk_o, 0);

    // read collides with third-word completion (R8, R7)
    @(posedge clk_i); #1;
    nine_bit_i = 1'b1; slave_reset(9);
    tx_q[0] = 9'h101; tx_q[1] = 9'h0F2; tx_q[2] = 9'h1E3; tx_q[3] = 9'h000;
    cont_en_i = 1'b1;
    wait (rise_cnt == 27);
    repeat (3) @(posedge clk_i);
    #1 rd_i = 1'b1;
    @(posedge clk_i); #1 rd_i = 1'b0;
    @(negedge clk_i);
    check("R8 no overrun on collide", ovr_o, 0);
    check("R7 head data", rx_data_o, 8'hF2);
    check("R7 head bit9", rx_bit9_o, 0);
    @(posedge clk_i); #1 pop(); cont_en_i = 1'b0;
    @(negedge clk_i);
    check("R8 third data", rx_data_o, 8'hE3);
    check("R7 third bit9", rx_bit9_o, 1);
    @(posedge clk_i); #1 pop();
    @(negedge clk_i);
    check("R6 empty end", avail_o, 0);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule